// File: doc/BRIEF.md
# Key-Protected Sequence Lookup Table

This block stores the instruction sequences that a serial-flash sequencer executes. The storage is 64 words of 32 bits each. The words are grouped four at a time into 16 sequences. Each word packs two 16-bit instructions. Each instruction has a 6-bit opcode, a 2-bit pad count (the number of data lines it uses) and an 8-bit operand. Software reaches the table over a simple register bus with one-cycle read latency. The sequencer fetches words through a separate read port that it addresses by sequence number and step. That port also presents the two instructions of the fetched word already split into their fields.

Changes to the table are guarded by a two-write handshake. First, a fixed 32-bit key value is written to the key register. The very next bus write must then go to the lock-control register and carry either the lock command or the unlock command. While the table is locked, writes to its words are dropped without notice. Reads are never blocked.

After reset the table is unlocked and every word is zero. A driver can therefore load its sequences and then lock the table against stray writes.

Top module: `seqtab_lut_top`

## Requirements
- R1: After reset every table word reads as zero, on both the bus and the sequencer port, and the table is unlocked.
- R2: While the table is unlocked, a bus write to word address 0..63 stores the data. A bus read with `reg_rd_en` high returns that word on `reg_rdata` in the following cycle.
- R3: A write of 0x5AF05AF0 to address 64, followed as the next bus write by a write of 1 to address 65, locks the table. A repeated correct key write keeps the key armed.
- R4: While the table is locked, bus writes to word addresses are ignored, and bus and sequencer reads still return the stored contents.
- R5: The key write followed as the next bus write by a write of 2 to address 65 unlocks the table. Table writes take effect again from then on.
- R6: A lock-control write that does not directly follow a correct key write changes nothing. This includes a write that follows a wrong key value.
- R7: Any other bus write between the key write and the lock-control write disarms the key, so the command is ignored.
- R8: A lock-control value other than 1 or 2 after the key changes nothing and disarms the key.
- R9: The sequencer port returns word `seq_id*4 + seq_idx` on `seq_word` one cycle after the ID and index are presented.
- R10: The sequencer port splits the fetched word into two instructions. The first has opcode at bits [15:10], pad count at [9:8] and operand at [7:0]. The second has the same layout in bits [31:16].
- R11: Bus reads do not disarm an armed key.
- R12: Bus reads of addresses 64 and 65 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Bus write strobe |
| reg_rd_en | input | 1 | Bus read strobe |
| reg_addr | input | 7 | Word address: 0..63 table, 64 key, 65 lock control |
| reg_wdata | input | 32 | Bus write data |
| reg_rdata | output | 32 | Bus read data, valid the cycle after the read strobe |
| seq_id | input | 4 | Sequence number for the sequencer fetch |
| seq_idx | input | 2 | Step within the sequence |
| seq_word | output | 32 | Fetched word, one cycle later |
| seq_op0 | output | 6 | First instruction opcode |
| seq_pad0 | output | 2 | First instruction pad count |
| seq_opr0 | output | 8 | First instruction operand |
| seq_op1 | output | 6 | Second instruction opcode |
| seq_pad1 | output | 2 | Second instruction pad count |
| seq_opr1 | output | 8 | Second instruction operand |

## Verification
The bench goes after the arming window of the key. It places a table write, a read, a bad command value and a wrong key between the key and the command.

A design that armed on any key value would unlock after the wrong key. A design that kept the key armed across other writes would unlock after the intervening table write. A design that disarmed on reads would fail to unlock after a read.

The bench also writes to the table while it is locked and reads the word back through both ports. A missing write guard would show up as changed contents there. Finally, all 64 words are filled with distinct patterns and fetched through the sequencer port, which exposes address swaps and field slicing errors.

// File: rtl/seqtab_pkg.sv
// Shared types for the sequence lookup table.
// Assumes each table word holds exactly two 16-bit instructions.
package seqtab_pkg;

    typedef struct packed {
        logic [5:0] opcode;
        logic [1:0] pads;
        logic [7:0] operand;
    } seq_instr_t;

    typedef struct packed {
        seq_instr_t hi;
        seq_instr_t lo;
    } seq_entry_t;

    typedef enum logic {
        TAB_OPEN = 1'b0,
        TAB_SHUT = 1'b1
    } lock_state_e;

    localparam int ENTRY_W = $bits(seq_entry_t);
    localparam int INSTR_W = $bits(seq_instr_t);
    localparam int SLOTS   = ENTRY_W / INSTR_W;

endpackage

// File: rtl/seqtab_keylock.sv
// Key-armed lock controller.
// A correct key write arms the controller. The very next bus write decides:
// if it goes to the lock-control register with a known command, the lock
// state changes. Any write disarms the key; reads leave it alone.
// Assumes at most one of key_wr, ctrl_wr and other_wr is high per cycle.
module seqtab_keylock #(
    parameter int          DATA_W     = 32,
    parameter logic [31:0] KEY        = 32'h5AF0_5AF0,
    parameter int          CMD_LOCK   = 1,
    parameter int          CMD_UNLOCK = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_wr,
    input  logic              ctrl_wr,
    input  logic              other_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic              locked
);
    import seqtab_pkg::*;

    localparam logic [DATA_W-1:0] KEY_V    = DATA_W'(KEY);
    localparam logic [DATA_W-1:0] LOCK_V   = DATA_W'(CMD_LOCK);
    localparam logic [DATA_W-1:0] UNLOCK_V = DATA_W'(CMD_UNLOCK);

    logic        armed_q;
    lock_state_e state_q;
    logic        key_ok;

    assign key_ok = key_wr && (wdata == KEY_V);
    assign locked = (state_q == TAB_SHUT);

    // Arm on a correct key write; disarm on any other bus write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (key_ok) begin
            armed_q <= 1'b1;
        end else if (key_wr || ctrl_wr || other_wr) begin
            armed_q <= 1'b0;
        end
    end

    // Apply a lock or unlock command only while the key is armed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TAB_OPEN;
        end else if (ctrl_wr && armed_q) begin
            if (wdata == LOCK_V) begin
                state_q <= TAB_SHUT;
            end else if (wdata == UNLOCK_V) begin
                state_q <= TAB_OPEN;
            end
        end
    end

    // R3: locking only follows an armed lock command
    a_r3_lock_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(armed_q) && $past(ctrl_wr) && ($past(wdata) == LOCK_V)));

    // R5: unlocking only follows an armed unlock command
    a_r5_unlock_needs_key: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> ($past(armed_q) && $past(ctrl_wr) && ($past(wdata) == UNLOCK_V)));

    // R6: a command without an armed key leaves the state alone
    a_r6_unarmed_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !armed_q) |=> $stable(locked));

    // R7: any write that is not a correct key leaves the key disarmed
    a_r7_write_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        (other_wr || ctrl_wr || (key_wr && (wdata != KEY_V))) |=> !armed_q);

endmodule

// File: rtl/seqtab_store.sv
// Table storage: one guarded write port, one registered bus read port and
// one registered sequencer read port that samples every cycle.
// Assumes the caller keeps waddr and raddr_a inside the table range.
module seqtab_store #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_req,
    input  logic              wr_allow,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_a_en,
    input  logic [AW-1:0]     raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [AW-1:0]     raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Clear on reset; store a write only when the lock allows it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
        end else if (wr_req && wr_allow) begin
            mem[waddr] <= wdata;
        end
    end

    // Bus read port: capture the addressed word when a read is requested.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_a <= '0;
        end else if (rd_a_en) begin
            rdata_a <= mem[raddr_a];
        end
    end

    // Sequencer read port: capture the addressed word every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_b <= '0;
        end else begin
            rdata_b <= mem[raddr_b];
        end
    end

    // R2: an allowed write is held in the addressed word
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_allow) |=> (mem[$past(waddr)] == $past(wdata)));

    // R4: a refused write leaves the addressed word untouched
    a_r4_locked_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_allow) |=> (mem[$past(waddr)] == $past(mem[waddr])));

endmodule

// File: rtl/seqtab_decode.sv
// Splits one table word into its instruction slots and their fields.
// Purely combinational; slot 0 is the low half of the word.
module seqtab_decode (
    input  seqtab_pkg::seq_entry_t                         entry,
    output seqtab_pkg::seq_instr_t [seqtab_pkg::SLOTS-1:0] slots
);
    import seqtab_pkg::*;

    // One slice per instruction slot.
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign slots[g] = seq_instr_t'(entry[g*INSTR_W +: INSTR_W]);
    end

endmodule

// File: rtl/seqtab_lut_top.sv
// Key-protected sequence lookup table.
// Bus map: word addresses 0..DEPTH-1 select table words, DEPTH is the key
// register and DEPTH+1 is the lock-control register. Anything else above
// the table is write-ignored and reads as zero. Reads take one cycle.
// Assumes the bus does not issue a read and a write in the same cycle.
module seqtab_lut_top #(
    parameter int          SEQ_NUM    = 16,
    parameter int          SEQ_LEN    = 4,
    parameter logic [31:0] KEY        = 32'h5AF0_5AF0,
    parameter int          CMD_LOCK   = 1,
    parameter int          CMD_UNLOCK = 2,
    localparam int DEPTH  = SEQ_NUM * SEQ_LEN,
    localparam int TAB_AW = $clog2(DEPTH),
    localparam int BUS_AW = TAB_AW + 1,
    localparam int ID_W   = $clog2(SEQ_NUM),
    localparam int IX_W   = $clog2(SEQ_LEN),
    localparam int DATA_W = seqtab_pkg::ENTRY_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [BUS_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [ID_W-1:0]   seq_id,
    input  logic [IX_W-1:0]   seq_idx,
    output logic [DATA_W-1:0] seq_word,
    output logic [5:0]        seq_op0,
    output logic [1:0]        seq_pad0,
    output logic [7:0]        seq_opr0,
    output logic [5:0]        seq_op1,
    output logic [1:0]        seq_pad1,
    output logic [7:0]        seq_opr1
);
    import seqtab_pkg::*;

    localparam logic [BUS_AW-1:0] KEY_ADDR  = BUS_AW'(DEPTH);
    localparam logic [BUS_AW-1:0] CTRL_ADDR = BUS_AW'(DEPTH + 1);

    logic              tab_hit, key_hit, ctrl_hit;
    logic              locked;
    logic              tab_rd_q;
    logic [DATA_W-1:0] tab_rdata;
    seq_instr_t [SLOTS-1:0] slots;

    assign tab_hit  = (reg_addr < BUS_AW'(DEPTH));
    assign key_hit  = (reg_addr == KEY_ADDR);
    assign ctrl_hit = (reg_addr == CTRL_ADDR);

    seqtab_keylock #(
        .DATA_W     (DATA_W),
        .KEY        (KEY),
        .CMD_LOCK   (CMD_LOCK),
        .CMD_UNLOCK (CMD_UNLOCK)
    ) lock_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .key_wr   (reg_wr_en && key_hit),
        .ctrl_wr  (reg_wr_en && ctrl_hit),
        .other_wr (reg_wr_en && !key_hit && !ctrl_hit),
        .wdata    (reg_wdata),
        .locked   (locked)
    );

    seqtab_store #(
        .DEPTH  (DEPTH),
        .DATA_W (DATA_W)
    ) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req   (reg_wr_en && tab_hit),
        .wr_allow (!locked),
        .waddr    (reg_addr[TAB_AW-1:0]),
        .wdata    (reg_wdata),
        .rd_a_en  (reg_rd_en && tab_hit),
        .raddr_a  (reg_addr[TAB_AW-1:0]),
        .rdata_a  (tab_rdata),
        .raddr_b  ({seq_id, seq_idx}),
        .rdata_b  (seq_word)
    );

    seqtab_decode dec_i (
        .entry (seq_entry_t'(seq_word)),
        .slots (slots)
    );

    // Remember whether the last bus read targeted the table.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tab_rd_q <= 1'b0;
        end else if (reg_rd_en) begin
            tab_rd_q <= tab_hit;
        end
    end

    assign reg_rdata = tab_rd_q ? tab_rdata : '0;

    assign seq_op0  = slots[0].opcode;
    assign seq_pad0 = slots[0].pads;
    assign seq_opr0 = slots[0].operand;
    assign seq_op1  = slots[1].opcode;
    assign seq_pad1 = slots[1].pads;
    assign seq_opr1 = slots[1].operand;

    // R12: reads outside the table return zero
    a_r12_nontable_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_en && !tab_hit) |=> (reg_rdata == '0));

endmodule

// File: tb/seqtab_lut_top_tb_top.sv
// Scoreboard bench: driver tasks push expected words, monitors compare.
module seqtab_lut_top_tb_top;

    localparam logic [31:0] KEY = 32'h5AF0_5AF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic        reg_rd_en = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  seq_id = '0;
    logic [1:0]  seq_idx = '0;
    logic [31:0] seq_word;
    logic [5:0]  seq_op0, seq_op1;
    logic [1:0]  seq_pad0, seq_pad1;
    logic [7:0]  seq_opr0, seq_opr1;

    always #5 clk = ~clk;

    seqtab_lut_top dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .seq_id(seq_id), .seq_idx(seq_idx), .seq_word(seq_word),
        .seq_op0(seq_op0), .seq_pad0(seq_pad0), .seq_opr0(seq_opr0),
        .seq_op1(seq_op1), .seq_pad1(seq_pad1), .seq_opr1(seq_opr1)
    );

    logic [31:0] m_mem [64];
    bit          m_locked = 1'b0;
    bit          m_armed  = 1'b0;
    logic [31:0] rd_exp_q[$];
    string       rd_tag_q[$];
    logic [31:0] sq_exp_q[$];
    string       sq_tag_q[$];
    bit          seq_chk = 1'b0;
    bit          pend_rd = 1'b0;
    bit          pend_sq = 1'b0;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    function automatic logic [31:0] mk(input logic [5:0] o0, input logic [1:0] p0,
                                       input logic [7:0] r0, input logic [5:0] o1,
                                       input logic [1:0] p1, input logic [7:0] r1);
        return {o1, p1, r1, o0, p0, r0};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one bus write, with the lock rules applied to the model.
    task automatic bus_wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        if (a < 7'd64) begin
            if (!m_locked) m_mem[a[5:0]] = d;
            m_armed = 1'b0;
        end else if (a == 7'd64) begin
            m_armed = (d == KEY);
        end else if (a == 7'd65) begin
            if (m_armed && d == 32'd1) m_locked = 1'b1;
            else if (m_armed && d == 32'd2) m_locked = 1'b0;
            m_armed = 1'b0;
        end else begin
            m_armed = 1'b0;
        end
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    // Driver: one bus read, expected value pushed to the scoreboard.
    task automatic bus_rd(input logic [6:0] a, input string tag);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = a;
        rd_exp_q.push_back((a < 7'd64) ? m_mem[a[5:0]] : 32'h0);
        rd_tag_q.push_back(tag);
        @(negedge clk);
        reg_rd_en = 1'b0;
    endtask

    // Driver: one sequencer fetch, expected word pushed to the scoreboard.
    task automatic seq_rd(input logic [3:0] id, input logic [1:0] ix, input string tag);
        @(negedge clk);
        seq_id = id; seq_idx = ix; seq_chk = 1'b1;
        sq_exp_q.push_back(m_mem[{id, ix}]);
        sq_tag_q.push_back(tag);
        @(negedge clk);
        seq_chk = 1'b0;
    endtask

    // Monitor bookkeeping: note which results are due at the next falling edge.
    always @(posedge clk) begin
        pend_rd <= reg_rd_en;
        pend_sq <= seq_chk;
    end

    // Monitor: compare the due results against the scoreboard.
    always @(negedge clk) begin
        if (pend_rd) begin
            if (rd_exp_q.size() == 0) begin
                chk("bus scoreboard empty", 32'h1, 32'h0);
            end else begin
                chk(rd_tag_q.pop_front(), reg_rdata, rd_exp_q.pop_front());
            end
        end
        if (pend_sq) begin
            if (sq_exp_q.size() == 0) begin
                chk("seq scoreboard empty", 32'h1, 32'h0);
            end else begin
                logic [31:0] e;
                string t;
                e = sq_exp_q.pop_front();
                t = sq_tag_q.pop_front();
                chk({t, " word"}, seq_word, e);
                chk({t, " R10 fields"},
                    {seq_op1, seq_pad1, seq_opr1, seq_op0, seq_pad0, seq_opr0}, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) m_mem[i] = 32'h0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: cleared and unlocked after reset
        bus_rd(7'd0, "R1 word0 after reset");
        bus_rd(7'd63, "R1 word63 after reset");
        seq_rd(4'd15, 2'd3, "R1 seq 15/3 after reset");

        // R2: writes land while unlocked
        bus_wr(7'd0, mk(6'h01, 2'd0, 8'h9F, 6'h07, 2'd2, 8'h10));
        bus_wr(7'd5, mk(6'h2A, 2'd1, 8'h5C, 6'h15, 2'd3, 8'hA3));
        bus_wr(7'd63, 32'hDEAD_BEEF);
        bus_rd(7'd0, "R2 word0");
        bus_rd(7'd5, "R2 word5");
        bus_rd(7'd63, "R2 word63");

        // R9: word 5 is sequence 1 step 1
        seq_rd(4'd1, 2'd1, "R9 seq 1/1");
        seq_rd(4'd15, 2'd3, "R9 seq 15/3");

        // R3: key then lock command
        bus_wr(7'd64, KEY);
        bus_wr(7'd65, 32'd1);
        // R4: table write while locked is dropped
        bus_wr(7'd0, 32'h1111_1111);
        bus_rd(7'd0, "R4 word0 after locked write");
        seq_rd(4'd0, 2'd0, "R4 seq 0/0 after locked write");

        // R6: unlock without key
        bus_wr(7'd65, 32'd2);
        bus_wr(7'd1, 32'h2222_2222);
        bus_rd(7'd1, "R6 no key, still locked");
        // R6: wrong key value
        bus_wr(7'd64, KEY ^ 32'h1);
        bus_wr(7'd65, 32'd2);
        bus_wr(7'd1, 32'h2222_2222);
        bus_rd(7'd1, "R6 wrong key, still locked");

        // R7: intervening table write disarms
        bus_wr(7'd64, KEY);
        bus_wr(7'd7, 32'h7777_7777);
        bus_wr(7'd65, 32'd2);
        bus_wr(7'd7, 32'h7777_7777);
        bus_rd(7'd7, "R7 intervening write, still locked");
        // R7: intervening write to an unmapped address disarms
        bus_wr(7'd64, KEY);
        bus_wr(7'd100, 32'h0);
        bus_wr(7'd65, 32'd2);
        bus_wr(7'd7, 32'h7777_7777);
        bus_rd(7'd7, "R7 unmapped write, still locked");

        // R8: bad command value, then a bare unlock
        bus_wr(7'd64, KEY);
        bus_wr(7'd65, 32'd3);
        bus_wr(7'd65, 32'd2);
        bus_wr(7'd2, 32'h3333_3333);
        bus_rd(7'd2, "R8 bad command disarms");

        // R11 and R5: a read between key and unlock keeps the key armed
        bus_wr(7'd64, KEY);
        bus_rd(7'd5, "R11 read while armed");
        bus_wr(7'd65, 32'd2);
        bus_wr(7'd0, 32'h0BAD_F00D);
        bus_rd(7'd0, "R5 write lands after unlock");
        bus_rd(7'd5, "R5 word5 kept");

        // R12: key and control registers read as zero
        bus_rd(7'd64, "R12 key reg reads zero");
        bus_wr(7'd64, KEY);
        bus_rd(7'd65, "R12 ctrl reg reads zero");
        bus_wr(7'd65, 32'd1);

        // R3: a repeated key keeps the key armed, lock follows
        bus_wr(7'd65, 32'd2);
        bus_wr(7'd64, KEY);
        bus_wr(7'd64, KEY);
        bus_wr(7'd65, 32'd1);
        bus_wr(7'd3, 32'h4444_4444);
        bus_rd(7'd3, "R3 double key then lock");
        bus_wr(7'd64, KEY);
        bus_wr(7'd65, 32'd2);

        // R9 and R10: fill every word, fetch all through the sequencer port
        for (int i = 0; i < 64; i++) begin
            bus_wr(7'(i), mk(6'(i + 3), 2'(i), 8'(i * 7 + 1), 6'(63 - i), 2'(i >> 2), 8'(i ^ 8'hA5)));
        end
        for (int s = 0; s < 16; s++) begin
            for (int k = 0; k < 4; k++) begin
                seq_rd(4'(s), 2'(k), "R9 full sweep");
            end
        end
        bus_rd(7'd42, "R2 sweep bus readback");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule